// File: doc/BRIEF.md
# DMA Transfer Descriptor Error Checker

This block screens one channel's transfer descriptor before any data moves and keeps a record of the most recent channel fault. A checker strobe presents the source and destination start addresses, the signed two's-complement source and destination address increments, the source and destination access-size codes, and the minor-loop byte count. The block reports any inconsistency at once on a combinational flag. It also records the fault, together with the channel number and a set of cause bits, in a single status register.

Bus fault indications from the read side and the write side of the transfer engine feed the same status register. The register therefore always shows the last fault of either kind. A valid bit marks the register as holding a fault. That bit stays set until a clear strobe empties the register. Address generation and data movement are handled elsewhere.

Top module: `dma_cfg_err_chk`

## Requirements
- R1: After reset the status register reads err_valid=0, err_chan=0 and err_cause=0, and desc_err is 0 while chk_valid is low.
- R2: Size codes 0, 1, 2 and 4 select 1, 2, 4 and 16-byte accesses. Any other code sets cause bit 5 (source) or bit 6 (destination). For that side it then raises no address, offset or byte-count cause.
- R3: A start address whose low bits are not zero modulo its own legal access size sets cause bit 0 (source) or bit 1 (destination).
- R4: An address increment, taken as a two's-complement value, that is not a multiple of its side's legal access size sets cause bit 2 (source) or bit 3 (destination). Negative increments are included.
- R5: A minor-loop byte count that is not a multiple of every legal access size of the two sides sets cause bit 4. A count of zero counts as a multiple.
- R6: desc_err is high in the same cycle that chk_valid is high and at least one descriptor cause is present.
- R7: A read bus fault sets cause bit 7 and a write bus fault sets cause bit 8. Both bits are set if both faults arrive together. bus_chan is recorded as the channel. All of this is visible from the next cycle.
- R8: When a bus fault and a faulty descriptor arrive in the same cycle, only the bus fault is recorded, and cause bits 6 to 0 read zero.
- R9: Each newly recorded fault replaces the channel and all cause bits. No bit from an earlier fault remains.
- R10: err_valid stays set until clr. A clr with no new fault in that cycle returns all three status fields to zero in the next cycle.
- R11: A fault arriving in the same cycle as clr is recorded, and the clear is dropped.
- R12: A cycle with no fault leaves the status register unchanged. This includes a faulty descriptor presented while chk_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | Descriptor check strobe |
| chk_chan | input | CH_W | Channel of the presented descriptor |
| src_addr | input | AW | Source start address |
| dst_addr | input | AW | Destination start address |
| src_off | input | OW | Source address increment, two's complement |
| dst_off | input | OW | Destination address increment, two's complement |
| src_size | input | 3 | Source access-size code |
| dst_size | input | 3 | Destination access-size code |
| nbytes | input | NBW | Minor-loop byte count |
| rd_bus_err | input | 1 | Read cycle ended in a bus fault |
| wr_bus_err | input | 1 | Write cycle ended in a bus fault |
| bus_chan | input | CH_W | Channel owning the faulted bus cycle |
| clr | input | 1 | Status clear strobe |
| desc_err | output | 1 | Presented descriptor is inconsistent |
| err_valid | output | 1 | Status register holds a fault |
| err_chan | output | CH_W | Channel of the last fault |
| err_cause | output | 9 | Cause bits of the last fault |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions: a bus fault together with a faulty descriptor, and a fault together with clr. A further hard case is an illegal size code combined with misaligned fields, where the size cause must be the only cause for that side. Uniform random fields almost never yield a clean descriptor, so the stimulus clears the low address, increment and count bits in a large share of trials. It raises bus faults and clr independently at moderate rates, so collisions happen often. Directed cases add negative increments, 16-byte sizes against an 8-byte count, and a faulty descriptor with the strobe low.

// File: rtl/dcec_pkg.sv
package dcec_pkg;
  localparam int CAUSE_W  = 9;
  localparam int C_SADDR  = 0;
  localparam int C_DADDR  = 1;
  localparam int C_SOFF   = 2;
  localparam int C_DOFF   = 3;
  localparam int C_NBYTES = 4;
  localparam int C_SSIZE  = 5;
  localparam int C_DSIZE  = 6;
  localparam int C_RDBUS  = 7;
  localparam int C_WRBUS  = 8;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/dcec_rst_sync.sv
module dcec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/dcec_size_dec.sv
module dcec_size_dec (
  input  logic [2:0] code,
  output logic       legal,
  output logic [3:0] low_mask
);
  always_comb begin
    legal    = 1'b1;
    low_mask = 4'h0;
    case (code)
      3'd0:    low_mask = 4'h0;
      3'd1:    low_mask = 4'h1;
      3'd2:    low_mask = 4'h3;
      3'd4:    low_mask = 4'hf;
      default: legal    = 1'b0;
    endcase
  end
endmodule

// File: rtl/dcec_desc_chk.sv
module dcec_desc_chk
  import dcec_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OW  = 16,
  parameter int NBW = 16
) (
  input  logic [AW-1:0]  src_addr,
  input  logic [AW-1:0]  dst_addr,
  input  logic [OW-1:0]  src_off,
  input  logic [OW-1:0]  dst_off,
  input  logic [2:0]     src_size,
  input  logic [2:0]     dst_size,
  input  logic [NBW-1:0] nbytes,
  output cause_t         cause
);
  localparam int SIDES = 2;

  logic [AW-1:0] addr_s [SIDES];
  logic [OW-1:0] off_s  [SIDES];
  logic [2:0]    size_s [SIDES];
  logic [SIDES-1:0] a_bad, o_bad, n_bad, s_bad;

  assign addr_s[0] = src_addr;
  assign addr_s[1] = dst_addr;
  assign off_s[0]  = src_off;
  assign off_s[1]  = dst_off;
  assign size_s[0] = src_size;
  assign size_s[1] = dst_size;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    logic       legal;
    logic [3:0] mask;

    dcec_size_dec u_dec (
      .code     (size_s[g]),
      .legal    (legal),
      .low_mask (mask)
    );

    assign s_bad[g] = !legal;
    assign a_bad[g] = legal && |(addr_s[g] & {{(AW-4){1'b0}}, mask});
    assign o_bad[g] = legal && |(off_s[g]  & {{(OW-4){1'b0}}, mask});
    assign n_bad[g] = legal && |(nbytes    & {{(NBW-4){1'b0}}, mask});
  end

  always_comb begin
    cause           = '0;
    cause[C_SADDR]  = a_bad[0];
    cause[C_DADDR]  = a_bad[1];
    cause[C_SOFF]   = o_bad[0];
    cause[C_DOFF]   = o_bad[1];
    cause[C_NBYTES] = |n_bad;
    cause[C_SSIZE]  = s_bad[0];
    cause[C_DSIZE]  = s_bad[1];
  end
endmodule

// File: rtl/dcec_status.sv
module dcec_status
  import dcec_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            desc_hit,
  input  logic [CH_W-1:0] desc_chan,
  input  cause_t          desc_cause,
  input  logic            rd_err,
  input  logic            wr_err,
  input  logic [CH_W-1:0] bus_chan,
  output logic            err_valid,
  output logic [CH_W-1:0] err_chan,
  output cause_t          err_cause
);
  logic            load_en;
  logic            valid_d;
  logic [CH_W-1:0] chan_d;
  cause_t          cause_d;
  logic            bus_hit;

  assign bus_hit = rd_err || wr_err;

  always_comb begin
    load_en = 1'b0;
    valid_d = err_valid;
    chan_d  = err_chan;
    cause_d = err_cause;
    if (bus_hit) begin
      load_en          = 1'b1;
      valid_d          = 1'b1;
      chan_d           = bus_chan;
      cause_d          = '0;
      cause_d[C_RDBUS] = rd_err;
      cause_d[C_WRBUS] = wr_err;
    end else if (desc_hit) begin
      load_en = 1'b1;
      valid_d = 1'b1;
      chan_d  = desc_chan;
      cause_d = desc_cause;
    end else if (clr) begin
      load_en = 1'b1;
      valid_d = 1'b0;
      chan_d  = '0;
      cause_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_chan  <= '0;
      err_cause <= '0;
    end else if (load_en) begin
      err_valid <= valid_d;
      err_chan  <= chan_d;
      err_cause <= cause_d;
    end
  end

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !clr |=> err_valid);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !bus_hit && !desc_hit |=> !err_valid && err_cause == '0 && err_chan == '0);

  p_bus_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |=> err_valid && err_chan == $past(bus_chan)
            && err_cause[C_RDBUS] == $past(rd_err) && err_cause[C_WRBUS] == $past(wr_err));

  p_bus_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit && desc_hit |=> err_cause[C_DSIZE:0] == '0);

  p_clr_loses_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr && (bus_hit || desc_hit) |=> err_valid);

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit && !desc_hit && !clr |=> $stable(err_valid) && $stable(err_chan) && $stable(err_cause));
endmodule

// File: rtl/dma_cfg_err_chk.sv
module dma_cfg_err_chk
  import dcec_pkg::*;
#(
  parameter int CH_W = 4,
  parameter int AW   = 32,
  parameter int OW   = 16,
  parameter int NBW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_valid,
  input  logic [CH_W-1:0]    chk_chan,
  input  logic [AW-1:0]      src_addr,
  input  logic [AW-1:0]      dst_addr,
  input  logic [OW-1:0]      src_off,
  input  logic [OW-1:0]      dst_off,
  input  logic [2:0]         src_size,
  input  logic [2:0]         dst_size,
  input  logic [NBW-1:0]     nbytes,
  input  logic               rd_bus_err,
  input  logic               wr_bus_err,
  input  logic [CH_W-1:0]    bus_chan,
  input  logic               clr,
  output logic               desc_err,
  output logic               err_valid,
  output logic [CH_W-1:0]    err_chan,
  output logic [CAUSE_W-1:0] err_cause
);
  logic   rst_int_n;
  cause_t chk_cause;

  dcec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dcec_desc_chk #(.AW(AW), .OW(OW), .NBW(NBW)) u_chk (
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .src_off  (src_off),
    .dst_off  (dst_off),
    .src_size (src_size),
    .dst_size (dst_size),
    .nbytes   (nbytes),
    .cause    (chk_cause)
  );

  assign desc_err = chk_valid && (chk_cause != '0);

  dcec_status #(.CH_W(CH_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (clr),
    .desc_hit   (desc_err),
    .desc_chan  (chk_chan),
    .desc_cause (chk_cause),
    .rd_err     (rd_bus_err),
    .wr_err     (wr_bus_err),
    .bus_chan   (bus_chan),
    .err_valid  (err_valid),
    .err_chan   (err_chan),
    .err_cause  (err_cause)
  );

  p_desc_rec_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    desc_err && !rd_bus_err && !wr_bus_err |=>
      err_valid && err_chan == $past(chk_chan) && err_cause == $past(chk_cause));

  p_bad_size_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    chk_valid && (src_size == 3'd3 || dst_size == 3'd7) |-> desc_err);

  p_bad_size_only_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    src_size == 3'd5 |-> !chk_cause[C_SADDR] && !chk_cause[C_SOFF]);
endmodule

// File: tb/dma_cfg_err_chk_bench.sv
module dma_cfg_err_chk_bench;
  localparam int CH_W = 4;
  localparam int AW   = 32;
  localparam int OW   = 16;
  localparam int NBW  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic chk_valid, rd_bus_err, wr_bus_err, clr;
  logic [CH_W-1:0] chk_chan, bus_chan;
  logic [AW-1:0] src_addr, dst_addr;
  logic [OW-1:0] src_off, dst_off;
  logic [2:0] src_size, dst_size;
  logic [NBW-1:0] nbytes;
  logic desc_err, err_valid;
  logic [CH_W-1:0] err_chan;
  logic [8:0] err_cause;

  int checks = 0;
  int errors = 0;

  logic            m_valid;
  logic [CH_W-1:0] m_chan;
  logic [8:0]      m_cause;

  always #4 clk = ~clk;

  dma_cfg_err_chk #(.CH_W(CH_W), .AW(AW), .OW(OW), .NBW(NBW)) u_dma_cfg_err_chk (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_chan(chk_chan),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_off(src_off), .dst_off(dst_off),
    .src_size(src_size), .dst_size(dst_size), .nbytes(nbytes),
    .rd_bus_err(rd_bus_err), .wr_bus_err(wr_bus_err), .bus_chan(bus_chan), .clr(clr),
    .desc_err(desc_err), .err_valid(err_valid), .err_chan(err_chan), .err_cause(err_cause)
  );

  function automatic logic [4:0] size_info(input logic [2:0] code);
    // {legal, mask[3:0]}
    case (code)
      3'd0: return 5'b1_0000;
      3'd1: return 5'b1_0001;
      3'd2: return 5'b1_0011;
      3'd4: return 5'b1_1111;
      default: return 5'b0_0000;
    endcase
  endfunction

  function automatic logic [8:0] ref_cause(
      input logic [AW-1:0] sa, input logic [AW-1:0] da,
      input logic [OW-1:0] so, input logic [OW-1:0] dof,
      input logic [2:0] ss, input logic [2:0] ds, input logic [NBW-1:0] nb);
    logic [4:0] si, di;
    logic [8:0] c;
    si = size_info(ss);
    di = size_info(ds);
    c = '0;
    c[5] = !si[4];
    c[6] = !di[4];
    c[0] = si[4] && ((sa[3:0] & si[3:0]) != 0);
    c[1] = di[4] && ((da[3:0] & di[3:0]) != 0);
    c[2] = si[4] && ((so[3:0] & si[3:0]) != 0);
    c[3] = di[4] && ((dof[3:0] & di[3:0]) != 0);
    c[4] = (si[4] && ((nb[3:0] & si[3:0]) != 0)) || (di[4] && ((nb[3:0] & di[3:0]) != 0));
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    chk_valid = 0; chk_chan = '0; src_addr = '0; dst_addr = '0;
    src_off = '0; dst_off = '0; src_size = 3'd0; dst_size = 3'd0; nbytes = '0;
    rd_bus_err = 0; wr_bus_err = 0; bus_chan = '0; clr = 0;
  endtask

  // called at a falling edge with inputs already set
  task automatic apply(input string tag);
    logic [8:0] c;
    #1;
    c = ref_cause(src_addr, dst_addr, src_off, dst_off, src_size, dst_size, nbytes);
    check({tag, " R6 desc_err"}, {31'd0, desc_err}, {31'd0, chk_valid && (c != 0)});
    if (rd_bus_err || wr_bus_err) begin
      m_valid = 1; m_chan = bus_chan; m_cause = {wr_bus_err, rd_bus_err, 7'd0};
    end else if (chk_valid && c != 0) begin
      m_valid = 1; m_chan = chk_chan; m_cause = c;
    end else if (clr) begin
      m_valid = 0; m_chan = '0; m_cause = '0;
    end
    @(negedge clk);
    check({tag, " valid"}, {31'd0, err_valid}, {31'd0, m_valid});
    check({tag, " chan"},  {28'd0, err_chan},  {28'd0, m_chan});
    check({tag, " cause"}, {23'd0, err_cause}, {23'd0, m_cause});
  endtask

  function automatic logic [2:0] pick_size();
    int r = $urandom_range(0, 9);
    if (r < 8) return 3'((r % 4 == 3) ? 4 : r % 4);
    return 3'($urandom_range(0, 7));
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    idle();
    rst_n = 0;
    m_valid = 0; m_chan = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, err_valid}, 32'd0);
    check("R1 reset cause", {23'd0, err_cause}, 32'd0);
    check("R1 reset chan",  {28'd0, err_chan},  32'd0);
    check("R1 desc_err idle", {31'd0, desc_err}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R12: faulty descriptor with strobe low is ignored
    src_addr = 32'h3; src_size = 3'd2; apply("R12 strobe low");
    idle();
    // R3: source misaligned for 4 bytes
    chk_valid = 1; chk_chan = 4'd3; src_addr = 32'h1002; src_size = 3'd2;
    apply("R3 src addr");
    // R4: negative offsets, -4 legal and -2 illegal for 4 bytes
    idle(); chk_valid = 1; chk_chan = 4'd5; src_size = 3'd2; dst_size = 3'd2;
    src_off = 16'hfffc; dst_off = 16'hfffe; apply("R4 neg off");
    // R9: replace with clean source, only destination addr fault
    idle(); chk_valid = 1; chk_chan = 4'd6; dst_size = 3'd1; dst_addr = 32'h7; apply("R9 overwrite");
    // R5: 16-byte destination with an 8-byte count
    idle(); chk_valid = 1; chk_chan = 4'd7; dst_size = 3'd4; nbytes = 16'd8; apply("R5 nbytes");
    // R2: illegal size suppresses the other checks of that side
    idle(); chk_valid = 1; chk_chan = 4'd8; src_size = 3'd3; src_addr = 32'h5;
    src_off = 16'h3; nbytes = 16'h7; apply("R2 illegal size");
    // R7: both bus faults together
    idle(); rd_bus_err = 1; wr_bus_err = 1; bus_chan = 4'd9; apply("R7 both bus");
    // R8: bus fault with faulty descriptor
    idle(); rd_bus_err = 1; bus_chan = 4'd2; chk_valid = 1; chk_chan = 4'd11;
    dst_size = 3'd6; apply("R8 bus priority");
    // R11: fault with clear
    idle(); clr = 1; chk_valid = 1; chk_chan = 4'd12; src_size = 3'd1; src_addr = 32'h1;
    apply("R11 clr loses");
    // R10: clear alone, then sticky with no fault
    idle(); clr = 1; apply("R10 clear");
    idle(); apply("R10 idle after clear");
    // R12: clean descriptor leaves status alone
    idle(); chk_valid = 1; src_size = 3'd4; dst_size = 3'd4; nbytes = 16'd32;
    src_off = 16'hfff0; apply("R12 clean desc");

    for (int i = 0; i < 600; i++) begin
      idle();
      chk_valid = ($urandom_range(0, 9) < 8);
      chk_chan  = 4'($urandom);
      src_size  = pick_size();
      dst_size  = pick_size();
      src_addr  = $urandom; dst_addr = $urandom;
      src_off   = 16'($urandom); dst_off = 16'($urandom);
      nbytes    = 16'($urandom);
      if ($urandom_range(0, 9) < 4) begin
        src_addr[3:0] = 4'h0; dst_addr[3:0] = 4'h0;
        src_off[3:0] = 4'h0; dst_off[3:0] = 4'h0; nbytes[3:0] = 4'h0;
      end
      rd_bus_err = ($urandom_range(0, 9) == 0);
      wr_bus_err = ($urandom_range(0, 9) == 0);
      bus_chan   = 4'($urandom);
      clr        = ($urandom_range(0, 5) == 0);
      apply("R3 R4 R5 R9 random");
    end

    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule